// File: doc/BRIEF.md
# Protected Serial Flash Page Controller

This block lets a processor drive an 8-pin serial NOR flash through four byte-wide registers. Software stages one 256-byte page in an internal buffer through a data port whose pointer advances on every access. It selects the page with a 16-bit page number, which forms the upper 16 bits of the 24-bit byte address; the low 8 bits are always zero. It then asks for a page read, a page program or a 4 KiB sector erase. The controller runs the complete serial command sequence on its own: write-enable first where it is needed, then the command with its address, then status polling until the device reports that it is idle. Software sees only a busy bit and an error bit.

Before it touches the pins, the controller checks every program or erase request. Pages up to 0x02FF hold the configuration image and pages 0x0300 to 0x05FF hold program data. Each of these two regions is unlocked by its own security key bit, and both key bits drop at the end of every request, whether it succeeded or failed. An erase must also start on a sector boundary, which is every 16 pages. A request that fails a check leaves the serial pins idle and raises the error bit.

Register offsets on `regAddr`: 0 = data port, 1 = page number low byte, 2 = page number high byte, 3 = command (write) / status (read).

Top module: `spi_page_guard`

## Requirements
- R1: After reset, status reads 0x00, the page number reads 0x0000, `csN` is high, `sclk` is low and the buffer pointer is 0.
- R2: A status read (offset 3) returns busy in bit 0 and error in bit 1, with bits 7..2 always zero, even while key bits are set.
- R3: A data-port write (offset 0) stores the byte at the pointer and a data-port read returns the byte at the pointer. Both advance the pointer by one, and the pointer wraps from 255 to 0.
- R4: Command field bits 1..0 = 01 requests a page read. It sends one frame: 0x03, the page high byte, the page low byte, 0x00, then 256 clocked bytes that fill the buffer from index 0. When the request is done, the pointer is 0.
- R5: Command field 10 requests a page program. It sends a frame holding 0x06, then a frame of 0x02 with the three address bytes and buffer bytes 0..255, then a frame of 0x05 that keeps reading status bytes until bit 0 is clear.
- R6: Command field 11 requests a sector erase. It sends a frame holding 0x06, then a frame of 0x20 with the three address bytes, then the same 0x05 polling frame.
- R7: A program or erase request is legal only if the page is above 0x05FF, or the page is at most 0x02FF and the configuration key (command bit 6) is set, or the page is in 0x0300..0x05FF and the program key (command bit 7) is set. Reads need no key. Key bits written with field 00 are held, and key bits in a request write count for that request.
- R8: An erase whose page number has a nonzero low nibble is illegal.
- R9: An illegal request raises the error bit, never sets busy and produces no `csN` activity.
- R10: Both key bits clear at the end of every request, whether it is legal or illegal.
- R11: The error bit clears when a legal request is accepted. Key-only writes leave it unchanged.
- R12: While busy, all register writes are ignored, and data-port reads return 0 without moving the pointer.
- R13: The serial clock idles low while `csN` is high. `mosi` changes only while `sclk` is low (mode 0), and `miso` is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (only the data port has a read side effect) |
| regAddr | input | 2 | Register offset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from `regAddr` |
| sclk | output | 1 | Serial clock to the flash |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The assertions check on every cycle that the serial pins follow mode 0 and that the chip select stays high whenever the block is idle. They also check that a newly raised error never comes with busy or pin activity, that busy never rises with a stale error, and that the page number does not move during a request. Only the bench's scenarios can show that the correct opcode sequence and page data reach a behavioural flash responder, and that the region and key rules accept exactly the right requests. Those rules are exercised by a sweep of erase requests over boundary pages and all four key combinations. The scenarios also cover the one-shot life of the keys, pointer wrap, and the requests that are ignored while busy.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } opCode_e;

  typedef enum logic [2:0] {
    TX_OPC,
    TX_PAGE_HI,
    TX_PAGE_LO,
    TX_ZERO,
    TX_BUF
  } txSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       startByte;
    txSel_e     txSel;
    logic [7:0] opcode;
    logic       storeRx;
    logic       advPtr;
    logic       clrPtr;
    logic       csActive;
  } dpCtl_t;

  localparam logic [7:0] FL_WREN  = 8'h06;
  localparam logic [7:0] FL_READ  = 8'h03;
  localparam logic [7:0] FL_PROG  = 8'h02;
  localparam logic [7:0] FL_ERASE = 8'h20;
  localparam logic [7:0] FL_RDSR  = 8'h05;

  localparam logic [1:0] RA_DATA   = 2'd0;
  localparam logic [1:0] RA_PAGELO = 2'd1;
  localparam logic [1:0] RA_PAGEHI = 2'd2;
  localparam logic [1:0] RA_CMD    = 2'd3;

endpackage

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int HALF_CYC   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        busy,
  input  logic        err,
  input  dpCtl_t      ctl,
  output logic [15:0] page,
  output logic        engBusy,
  output logic        byteDone,
  output logic [7:0]  rxByte,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);

  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  logic [7:0]       bufArr [PAGE_BYTES];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       pageLo, pageHi;

  logic hostDataWr, hostDataRd, hostPageLoWr, hostPageHiWr;
  logic bufWe;
  logic [7:0] bufWd;

  assign hostDataWr   = regWr && !busy && (regAddr == RA_DATA);
  assign hostDataRd   = regRd && !busy && (regAddr == RA_DATA);
  assign hostPageLoWr = regWr && !busy && (regAddr == RA_PAGELO);
  assign hostPageHiWr = regWr && !busy && (regAddr == RA_PAGEHI);

  assign page = {pageHi, pageLo};

  // page number registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageLo <= 8'h00;
      pageHi <= 8'h00;
    end else begin
      if (hostPageLoWr) pageLo <= regWdata;
      if (hostPageHiWr) pageHi <= regWdata;
    end
  end

  // buffer pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.clrPtr) begin
      ptr <= '0;
    end else if (hostDataWr || hostDataRd || ctl.storeRx || ctl.advPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  // buffer storage
  assign bufWe = hostDataWr || ctl.storeRx;
  assign bufWd = ctl.storeRx ? rxByte : regWdata;

  always_ff @(posedge clk) begin
    if (bufWe) bufArr[ptr] <= bufWd;
  end

  // register read mux
  always_comb begin
    unique case (regAddr)
      RA_DATA:   regRdata = busy ? 8'h00 : bufArr[ptr];
      RA_PAGELO: regRdata = pageLo;
      RA_PAGEHI: regRdata = pageHi;
      default:   regRdata = {6'b0, err, busy};
    endcase
  end

  // byte shifter
  logic [7:0]      txByte;
  logic [7:0]      txSh, rxSh;
  logic [HC_W-1:0] halfCnt;
  logic [3:0]      edgeCnt;
  logic            active, sclkQ, doneQ, csNQ;

  always_comb begin
    unique case (ctl.txSel)
      TX_OPC:     txByte = ctl.opcode;
      TX_PAGE_HI: txByte = pageHi;
      TX_PAGE_LO: txByte = pageLo;
      TX_BUF:     txByte = bufArr[ptr];
      default:    txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      sclkQ   <= 1'b0;
      doneQ   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      txSh    <= 8'h00;
      rxSh    <= 8'h00;
    end else begin
      doneQ <= 1'b0;
      if (!active) begin
        if (ctl.startByte) begin
          active  <= 1'b1;
          txSh    <= txByte;
          halfCnt <= '0;
          edgeCnt <= '0;
        end
      end else if (halfCnt == HC_LAST) begin
        halfCnt <= '0;
        sclkQ   <= ~sclkQ;
        if (!sclkQ) begin
          rxSh <= {rxSh[6:0], miso};
        end else begin
          txSh <= {txSh[6:0], 1'b0};
        end
        edgeCnt <= edgeCnt + 4'd1;
        if (edgeCnt == 4'd15) begin
          active <= 1'b0;
          doneQ  <= 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csNQ <= 1'b1;
    else       csNQ <= ~ctl.csActive;
  end

  assign engBusy  = active;
  assign byteDone = doneQ;
  assign rxByte   = rxSh;
  assign sclk     = sclkQ;
  assign mosi     = txSh[7];
  assign csN      = csNQ;

endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int          PAGE_BYTES   = 256,
  parameter logic [15:0] CFG_LAST     = 16'h02FF,
  parameter logic [15:0] PROG_LAST    = 16'h05FF,
  parameter int          SECTOR_PAGES = 16,
  parameter int          CS_GAP       = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  input  logic [15:0] page,
  input  logic        engBusy,
  input  logic        byteDone,
  input  logic [7:0]  rxByte,
  output dpCtl_t      ctl,
  output logic        busy,
  output logic        err
);

  localparam int IDX_W = $clog2(PAGE_BYTES + 4);
  localparam int SEC_W = $clog2(SECTOR_PAGES);
  localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_PAGE = IDX_W'(PAGE_BYTES + 3);
  localparam logic [IDX_W-1:0] IDX_ERS  = IDX_W'(3);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_GAP1, ST_XFER, ST_GAP2, ST_POLL, ST_DONE
  } state_e;

  state_e           state;
  opCode_e          opQ, reqOp;
  logic             cfgKey, progKey, errQ;
  logic [IDX_W-1:0] byteIdx, lastIdx;
  logic [GAP_W-1:0] gapCnt;

  logic cmdWr, keyCfgNow, keyProgNow, inCfg, inProg, keysOk, aligned, legal, issue;
  logic unusedBits;

  assign unusedBits = ^{regWdata[5:2], rxByte[7:1]};

  assign cmdWr      = regWr && (regAddr == RA_CMD) && (state == ST_IDLE);
  assign reqOp      = opCode_e'(regWdata[1:0]);
  assign keyCfgNow  = cfgKey  | regWdata[6];
  assign keyProgNow = progKey | regWdata[7];

  // region and alignment screening
  assign inCfg   = (page <= CFG_LAST);
  assign inProg  = (page > CFG_LAST) && (page <= PROG_LAST);
  assign keysOk  = (!inCfg || keyCfgNow) && (!inProg || keyProgNow);
  assign aligned = (page[SEC_W-1:0] == '0);
  assign legal   = (reqOp == OP_READ) ||
                   ((reqOp == OP_WRITE) && keysOk) ||
                   ((reqOp == OP_ERASE) && keysOk && aligned);

  assign lastIdx = (opQ == OP_ERASE) ? IDX_ERS : IDX_PAGE;
  assign issue   = !engBusy && !byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opQ     <= OP_NONE;
      cfgKey  <= 1'b0;
      progKey <= 1'b0;
      errQ    <= 1'b0;
      byteIdx <= '0;
      gapCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdWr) begin
            if (reqOp == OP_NONE) begin
              cfgKey  <= keyCfgNow;
              progKey <= keyProgNow;
            end else begin
              errQ <= !legal;
              if (legal) begin
                opQ     <= reqOp;
                byteIdx <= '0;
                gapCnt  <= '0;
                state   <= (reqOp == OP_READ) ? ST_XFER : ST_WREN;
              end else begin
                cfgKey  <= 1'b0;
                progKey <= 1'b0;
              end
            end
          end
        end
        ST_WREN: begin
          if (byteDone) begin
            gapCnt <= '0;
            state  <= ST_GAP1;
          end
        end
        ST_GAP1: begin
          if (gapCnt == GAP_LAST) begin
            byteIdx <= '0;
            state   <= ST_XFER;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (byteDone) begin
            if (byteIdx == lastIdx) begin
              byteIdx <= '0;
              gapCnt  <= '0;
              state   <= (opQ == OP_READ) ? ST_DONE : ST_GAP2;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        ST_GAP2: begin
          if (gapCnt == GAP_LAST) begin
            byteIdx <= '0;
            state   <= ST_POLL;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (byteDone) begin
            if (byteIdx == '0) byteIdx <= IDX_W'(1);
            else if (!rxByte[0]) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          cfgKey  <= 1'b0;
          progKey <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  function automatic logic [7:0] opcodeFor(opCode_e op);
    unique case (op)
      OP_WRITE: return FL_PROG;
      OP_ERASE: return FL_ERASE;
      default:  return FL_READ;
    endcase
  endfunction

  always_comb begin
    ctl        = '0;
    ctl.txSel  = TX_ZERO;
    ctl.clrPtr = (cmdWr && (reqOp != OP_NONE)) || (state == ST_DONE);
    unique case (state)
      ST_WREN: begin
        ctl.csActive  = 1'b1;
        ctl.startByte = issue;
        ctl.txSel     = TX_OPC;
        ctl.opcode    = FL_WREN;
      end
      ST_XFER: begin
        ctl.csActive  = 1'b1;
        ctl.startByte = issue;
        ctl.opcode    = opcodeFor(opQ);
        if (byteIdx == IDX_W'(0))      ctl.txSel = TX_OPC;
        else if (byteIdx == IDX_W'(1)) ctl.txSel = TX_PAGE_HI;
        else if (byteIdx == IDX_W'(2)) ctl.txSel = TX_PAGE_LO;
        else if (byteIdx == IDX_W'(3)) ctl.txSel = TX_ZERO;
        else ctl.txSel = (opQ == OP_WRITE) ? TX_BUF : TX_ZERO;
        if (byteDone && (byteIdx >= IDX_HDR)) begin
          ctl.storeRx = (opQ == OP_READ);
          ctl.advPtr  = (opQ == OP_WRITE);
        end
      end
      ST_POLL: begin
        ctl.csActive  = 1'b1;
        ctl.startByte = issue;
        ctl.txSel     = (byteIdx == '0) ? TX_OPC : TX_ZERO;
        ctl.opcode    = FL_RDSR;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign err  = errQ;

endmodule

// File: rtl/spi_page_guard.sv
module spi_page_guard
  import spg_pkg::*;
#(
  parameter int          PAGE_BYTES   = 256,
  parameter logic [15:0] CFG_LAST     = 16'h02FF,
  parameter logic [15:0] PROG_LAST    = 16'h05FF,
  parameter int          SECTOR_PAGES = 16,
  parameter int          HALF_CYC     = 2,
  parameter int          CS_GAP       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sclk,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);

  dpCtl_t      ctl;
  logic        busyQ, errQ, engBusy, byteDone;
  logic [7:0]  rxByte;
  logic [15:0] pageQ;

  spg_ctrl #(
    .PAGE_BYTES  (PAGE_BYTES),
    .CFG_LAST    (CFG_LAST),
    .PROG_LAST   (PROG_LAST),
    .SECTOR_PAGES(SECTOR_PAGES),
    .CS_GAP      (CS_GAP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .page    (pageQ),
    .engBusy (engBusy),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .ctl     (ctl),
    .busy    (busyQ),
    .err     (errQ)
  );

  spg_datapath #(
    .PAGE_BYTES(PAGE_BYTES),
    .HALF_CYC  (HALF_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .busy    (busyQ),
    .err     (errQ),
    .ctl     (ctl),
    .page    (pageQ),
    .engBusy (engBusy),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .sclk    (sclk),
    .csN     (csN),
    .mosi    (mosi),
    .miso    (miso)
  );

endmodule

// File: rtl/spg_chk.sv
module spg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        err,
  input logic        csN,
  input logic        sclk,
  input logic        mosi,
  input logic [15:0] page
);

  // R13
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R13
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> (!busy && csN));

  // R11
  busy_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !err);

  // R12
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(page));

  // R9
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

endmodule

bind spi_page_guard spg_chk u_chk (
  .clk (clk),
  .rstN(rstN),
  .busy(busyQ),
  .err (errQ),
  .csN (csN),
  .sclk(sclk),
  .mosi(mosi),
  .page(pageQ)
);

// File: tb/spi_page_guard_tb.sv
`timescale 1ns/1ps
module spi_page_guard_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sclk, csN, mosi;
  logic       miso = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  spi_page_guard u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // ---------------- behavioural flash responder ----------------
  logic [7:0]  fmem [int];
  logic [7:0]  opLog [$];
  int          frameCnt = 0;
  int          mBit = 0, mByte = 0, busyLeft = 0;
  logic [7:0]  inB = 8'h00, outB = 8'h00, mOp = 8'h00;
  logic [23:0] mAddr = 24'h0, lastAddr = 24'h0;
  bit          wel = 1'b0;

  function automatic logic [7:0] rdMem(logic [23:0] a);
    return fmem.exists(int'(a)) ? fmem[int'(a)] : 8'hFF;
  endfunction

  function automatic logic [7:0] statusByte();
    if (busyLeft > 0) begin
      busyLeft--;
      return 8'h01;
    end
    return 8'h00;
  endfunction

  task automatic handleByte(logic [7:0] b);
    if (mByte == 0) begin
      mOp = b;
      opLog.push_back(b);
      if (b == 8'h06) wel = 1'b1;
      if (b == 8'h05) outB = statusByte();
    end else if (mOp == 8'h05) begin
      outB = statusByte();
    end else if (mOp == 8'h03 || mOp == 8'h02 || mOp == 8'h20) begin
      if (mByte <= 3) mAddr = {mAddr[15:0], b};
      if (mOp == 8'h03 && mByte >= 3) outB = rdMem(mAddr + 24'(mByte - 3));
      if (mOp == 8'h02 && mByte >= 4 && wel)
        fmem[int'({mAddr[23:8], 8'(mAddr[7:0] + 8'(mByte - 4))})] = b;
    end
  endtask

  always @(negedge csN) begin
    frameCnt++;
    mBit = 0; mByte = 0; outB = 8'h00; miso = 1'b0; mOp = 8'h00;
  end

  always @(posedge csN) begin
    lastAddr = mAddr;
    if ((mOp == 8'h02 || mOp == 8'h20) && wel) begin
      if (mOp == 8'h20) begin
        for (int i = 0; i < 4096; i++) begin
          int k;
          k = int'({mAddr[23:12], 12'h000}) + i;
          if (fmem.exists(k)) fmem.delete(k);
        end
      end
      busyLeft = 3;
      wel = 1'b0;
    end
  end

  always @(posedge sclk) begin
    if (!csN) begin
      inB = {inB[6:0], mosi};
      mBit++;
      if (mBit == 8) begin
        mBit = 0;
        handleByte(inB);
        mByte++;
      end
    end
  end

  always @(negedge sclk) begin
    if (!csN) miso = outB[3'(7 - mBit)];
  end

  // ---------------- bench helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic setPage(logic [15:0] p);
    busWrite(2'd1, p[7:0]);
    busWrite(2'd2, p[15:8]);
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    int n;
    n = 0;
    do begin
      busRead(2'd3, s);
      n++;
    end while (s[0] && n < 40000);
  endtask

  task automatic clrLog();
    opLog.delete();
    frameCnt = 0;
  endtask

  function automatic int seq3();
    if (opLog.size() != 3) return -1;
    return int'({opLog[0], opLog[1], opLog[2]});
  endfunction

  function automatic bit expLegal(logic [15:0] p, bit kc, bit kp, bit isErase);
    bit ok;
    ok = (p > 16'h02FF || kc) && (p < 16'h0300 || p > 16'h05FF || kp);
    if (isErase && p[3:0] != 4'h0) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [7:0] wpat(int i);
    return 8'(i * 13 + 7) ^ 8'h3C;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- scenarios ----------------
  logic [15:0] sweepPages [11] = '{16'h0000, 16'h0010, 16'h02F0, 16'h02FF, 16'h0300,
                                   16'h0301, 16'h05F0, 16'h05FF, 16'h0600, 16'h0601,
                                   16'hFFF0};

  initial begin
    logic [7:0] s, d;
    int mism;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    busRead(2'd3, s); chk(s == 8'h00, "R1 status", s, 0);
    busRead(2'd1, s); chk(s == 8'h00, "R1 page lo", s, 0);
    busRead(2'd2, s); chk(s == 8'h00, "R1 page hi", s, 0);
    chk(csN == 1'b1 && sclk == 1'b0, "R1 pins", {csN, sclk}, 2);

    // R3 data port, pointer starts at 0 and wraps
    for (int i = 0; i < 256; i++) busWrite(2'd0, wpat(i));
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      busRead(2'd0, d);
      if (d != wpat(i)) mism++;
    end
    chk(mism == 0, "R3 buffer readback", mism, 0);
    busRead(2'd0, d);
    chk(d == wpat(0), "R3 pointer wrap", d, wpat(0));

    // R5 page program in the free region; R12 while busy
    clrLog();
    setPage(16'h0700);
    busWrite(2'd3, 8'h02);
    repeat (10) @(negedge clk);
    busRead(2'd3, s); chk(s == 8'h01, "R2 busy status", s, 1);
    busRead(2'd0, d); chk(d == 8'h00, "R12 data read while busy", d, 0);
    busWrite(2'd1, 8'h55);
    busWrite(2'd3, 8'h03);
    waitIdle();
    busRead(2'd1, s); chk(s == 8'h00, "R12 page write ignored", s, 0);
    chk(seq3() == 32'h060205, "R5 opcode frames", seq3(), 32'h060205);
    chk(lastAddr == 24'h070000, "R5 address", lastAddr, 24'h070000);
    mism = 0;
    for (int i = 0; i < 256; i++)
      if (rdMem({16'h0700, 8'(i)}) != wpat(i)) mism++;
    chk(mism == 0, "R5 programmed data", mism, 0);
    busRead(2'd3, s); chk(s == 8'h00, "R5 status after", s, 0);

    // R7 program region with program key
    for (int i = 0; i < 256; i++) busWrite(2'd0, 8'(255 - i));
    clrLog();
    setPage(16'h0310);
    busWrite(2'd3, 8'h82);
    waitIdle();
    chk(seq3() == 32'h060205, "R7 keyed program frames", seq3(), 32'h060205);
    mism = 0;
    for (int i = 0; i < 256; i++)
      if (rdMem({16'h0310, 8'(i)}) != 8'(255 - i)) mism++;
    chk(mism == 0, "R7 keyed program data", mism, 0);

    // R4 page read
    for (int i = 0; i < 256; i++) fmem[int'({16'h0123, 8'(i)})] = 8'(i * 7 + 3);
    clrLog();
    setPage(16'h0123);
    busWrite(2'd3, 8'h01);
    waitIdle();
    chk(opLog.size() == 1 && opLog[0] == 8'h03, "R4 single read frame", frameCnt, 1);
    chk(lastAddr == 24'h012300, "R4 address", lastAddr, 24'h012300);
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      busRead(2'd0, d);
      if (d != 8'(i * 7 + 3)) mism++;
    end
    chk(mism == 0, "R4 read data", mism, 0);

    // R7 R9 program rejections
    clrLog();
    setPage(16'h0000); busWrite(2'd3, 8'h02);
    busRead(2'd3, s); chk(s == 8'h02, "R9 cfg program without key", s, 2);
    setPage(16'h0400); busWrite(2'd3, 8'h42);
    busRead(2'd3, s); chk(s == 8'h02, "R7 wrong key for program region", s, 2);
    chk(frameCnt == 0, "R9 no pin activity", frameCnt, 0);

    // R2 R8 R10 R11 key lifetime
    busWrite(2'd3, 8'hC0);
    busRead(2'd3, s); chk(s == 8'h02, "R2 keys not visible", s, 2);
    clrLog();
    setPage(16'h0021); busWrite(2'd3, 8'h03);
    busRead(2'd3, s); chk(s == 8'h02, "R8 misaligned erase", s, 2);
    setPage(16'h0020); busWrite(2'd3, 8'h03);
    busRead(2'd3, s); chk(s == 8'h02, "R10 keys gone after reject", s, 2);
    chk(frameCnt == 0, "R9 rejects silent", frameCnt, 0);
    busWrite(2'd3, 8'h40);
    busRead(2'd3, s); chk(s == 8'h02, "R11 key write keeps error", s, 2);
    busWrite(2'd3, 8'h03);
    waitIdle();
    busRead(2'd3, s); chk(s == 8'h00, "R11 error cleared by legal", s, 0);
    chk(seq3() == 32'h062005, "R6 erase frames", seq3(), 32'h062005);
    clrLog();
    busWrite(2'd3, 8'h03);
    busRead(2'd3, s); chk(s == 8'h02, "R10 keys gone after success", s, 2);

    // R6 R7 R8 R9 erase sweep over boundary pages and key pairs
    for (int pi = 0; pi < 11; pi++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] p;
        bit lg;
        p = sweepPages[pi];
        lg = expLegal(p, k[0], k[1], 1'b1);
        fmem[int'({p, 8'h09})] = 8'hA5;
        clrLog();
        setPage(p);
        busWrite(2'd3, {k[1], k[0], 4'b0000, 2'b11});
        waitIdle();
        busRead(2'd3, s);
        chk(s == (lg ? 8'h00 : 8'h02), "R7 sweep status", s, lg ? 0 : 2);
        chk(frameCnt == (lg ? 3 : 0), "R9 sweep frames", frameCnt, lg ? 3 : 0);
        chk(fmem.exists(int'({p, 8'h09})) == !lg, "R6 sweep sector erased",
            fmem.exists(int'({p, 8'h09})), !lg);
      end
    end
    chk(csN == 1'b1 && sclk == 1'b0, "R13 idle pins", {csN, sclk}, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule